// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block pulls packets off a low-speed USB differential pair using only a free-running system clock. It has no PLL and no clock from the transmitter. Both line wires pass through two-flop synchronizers. A J-to-K transition inside the sync field restarts a bit timer that first waits half a bit and then fires once per bit period. At the nominal ratio a bit lasts 10+2/3 system clocks. The timer therefore uses a fractional accumulator that adds one leap clock on two of every three bits, so that over time the sample point stays in the middle of each bit.

The sync field is accepted once two K samples arrive back to back. After that, each sample is NRZI-decoded and the bit after six decoded ones is dropped. The remaining bits are assembled LSB first, and each byte is presented with a one-cycle strobe. A sample that finds both wires low closes the packet. A byte limit protects the buffer that follows, and once the limit is exceeded reception is abandoned. If the sync field never completes, an error pulse is raised and hunting starts again.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset all output strobes are low and the receiver accepts no packet until the synchronized line has shown J (dp=0, dm=1).
- R2: Line states are decoded from {dp,dm}: J = 01 (idle), K = 10, SE0 = 00.
- R3: A J-to-K edge realigns the bit timer. `rx_sop` pulses once when two consecutive bit samples are both K. Bytes counted against the limit start only after that pulse.
- R4: If SYNC_LIMIT bit samples pass after the first edge without a double K, `rx_sync_err` pulses once with no `rx_sop`, and the receiver hunts for the next edge.
- R5: The first sample falls CENTER clocks after the aligning edge. Later samples follow at DIV_INT or DIV_INT+1 clocks, with an average of DIV_INT + DIV_NUM/DIV_DEN (10+2/3 by default), so a packet of MAX_BYTES bytes at the nominal rate is received intact.
- R6: NRZI decoding: a sample equal to the previous one is a 1, a change is a 0. The reference level for the first data bit is the final sync K.
- R7: The bit that follows six consecutive decoded 1s is dropped and does not enter the data.
- R8: Bits are assembled LSB first. Each byte appears on `rx_data` together with a one-cycle `rx_valid`.
- R9: An SE0 sample during data pulses `rx_eop` once, discards any partial byte, and takes priority over a stuff bit that is due at that sample.
- R10: Byte MAX_BYTES+1 raises `rx_overflow` instead of `rx_valid`. The rest of that packet is ignored up to its SE0, and the next packet is received normally.
- R11: At most one of `rx_valid`, `rx_sop`, `rx_eop`, `rx_overflow`, `rx_sync_err` is high in any cycle.
- R12: An SE0 pulse on an idle bus (a keep-alive with no sync field) produces no output strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 32/3 times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| dp | input | 1 | D+ line, asynchronous |
| dm | input | 1 | D- line, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe, rx_data holds a new byte |
| rx_sop | output | 1 | One-cycle pulse, sync field accepted |
| rx_eop | output | 1 | One-cycle pulse, packet ended on SE0 |
| rx_overflow | output | 1 | One-cycle pulse, byte limit exceeded |
| rx_sync_err | output | 1 | One-cycle pulse, sync field never completed |

## Verification
Two events can land on the same bit sample: a due stuff bit (the decoder has just counted six ones) and the SE0 that ends the packet. The byte limit is also reached on that same packet. The bench provokes this with a directed packet of exactly MAX_BYTES bytes whose last byte ends in six ones, and it omits the trailing stuff bit so that the SE0 sample lands where the drop would have happened. It judges the result at the ports: all bytes must arrive, `rx_eop` must pulse once, and neither `rx_overflow` nor an extra byte may appear.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  // synchronized line code, packed as {dp, dm}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    ST_WAIT_IDLE,
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_WAIT_EOP
  } rx_state_t;

endpackage

// File: rtl/usb_ls_sync.sv
module usb_ls_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= {STAGES{RESET_VAL[g]}};
      else     sr <= {sr[STAGES-2:0], d[g]};
    end
    assign q[g] = sr[STAGES-1];
  end

endmodule

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
  parameter int DIV_INT = 10,
  parameter int DIV_NUM = 2,
  parameter int DIV_DEN = 3,
  parameter int CENTER  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int CW = $clog2(DIV_INT + CENTER + 2);
  localparam int FW = $clog2(2 * DIV_DEN + 1);

  logic [CW-1:0] cnt;
  logic [FW-1:0] acc;
  logic [FW-1:0] acc_sum;

  assign acc_sum = acc + FW'(DIV_NUM);
  assign tick    = run && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      acc <= '0;
    end else if (restart) begin
      cnt <= CW'(CENTER - 1);
      acc <= '0;
    end else if (cnt == '0) begin
      if (acc_sum >= FW'(DIV_DEN)) begin
        cnt <= CW'(DIV_INT);          // leap clock
        acc <= acc_sum - FW'(DIV_DEN);
      end else begin
        cnt <= CW'(DIV_INT - 1);
        acc <= acc_sum;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/usb_ls_nrzi_unstuff.sv
module usb_ls_nrzi_unstuff
  import usb_ls_rx_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  init,
  input  logic  tick,
  input  line_t line_i,
  output logic  bit_vld,
  output logic  bit_val,
  output logic  se0
);

  localparam int OW = $clog2(STUFF_RUN + 1);

  line_t         prev;
  logic [OW-1:0] ones;
  logic          same;
  logic          stuffed;

  assign se0     = tick && (line_i == LS_SE0);
  assign same    = (line_i == prev);
  assign stuffed = (ones == OW'(STUFF_RUN));
  assign bit_vld = tick && (line_i != LS_SE0) && !stuffed;
  assign bit_val = same;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      prev <= LS_K;
      ones <= '0;
    end else if (tick && line_i != LS_SE0) begin
      prev <= line_i;
      if (stuffed || !same) ones <= '0;
      else                  ones <= ones + 1'b1;
    end
  end

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int MAX_BYTES  = 8,
  parameter int DIV_INT    = 10,
  parameter int DIV_NUM    = 2,
  parameter int DIV_DEN    = 3,
  parameter int CENTER     = 5,
  parameter int STUFF_RUN  = 6,
  parameter int SYNC_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dp,
  input  logic       dm,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_sop,
  output logic       rx_eop,
  output logic       rx_overflow,
  output logic       rx_sync_err
);

  localparam int BCW = $clog2(MAX_BYTES + 1);
  localparam int SCW = $clog2(SYNC_LIMIT + 1);

  logic [1:0] sq;
  line_t      line, line_d;
  rx_state_t  state;
  logic       edge_jk, restart, run, tick, dtick;
  logic       bit_vld, bit_val, se0;
  logic       last_k;
  logic [SCW-1:0] sync_cnt;
  logic [BCW-1:0] byte_cnt;
  logic [2:0]     bit_cnt;
  logic [7:0]     sh;
  logic [7:0]     next_byte;

  usb_ls_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst), .d({dp, dm}), .q(sq)
  );

  assign line = line_t'(sq);

  always_ff @(posedge clk) begin
    if (rst) line_d <= LS_J;
    else     line_d <= line;
  end

  assign edge_jk = (line_d == LS_J) && (line == LS_K);
  assign restart = edge_jk && (state == ST_IDLE || state == ST_SYNC);
  assign run     = (state == ST_SYNC) || (state == ST_DATA);
  assign dtick   = tick && (state == ST_DATA);
  assign next_byte = {bit_val, sh[7:1]};

  usb_ls_bit_timer #(
    .DIV_INT(DIV_INT), .DIV_NUM(DIV_NUM), .DIV_DEN(DIV_DEN), .CENTER(CENTER)
  ) u_timer (
    .clk(clk), .rst(rst), .run(run), .restart(restart), .tick(tick)
  );

  usb_ls_nrzi_unstuff #(.STUFF_RUN(STUFF_RUN)) u_dec (
    .clk(clk), .rst(rst), .init(state != ST_DATA), .tick(dtick),
    .line_i(line), .bit_vld(bit_vld), .bit_val(bit_val), .se0(se0)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_WAIT_IDLE;
      last_k      <= 1'b0;
      sync_cnt    <= '0;
      byte_cnt    <= '0;
      bit_cnt     <= '0;
      sh          <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_sop      <= 1'b0;
      rx_eop      <= 1'b0;
      rx_overflow <= 1'b0;
      rx_sync_err <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      rx_sop      <= 1'b0;
      rx_eop      <= 1'b0;
      rx_overflow <= 1'b0;
      rx_sync_err <= 1'b0;
      case (state)
        ST_WAIT_IDLE: begin
          if (line == LS_J) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (edge_jk) begin
            state    <= ST_SYNC;
            last_k   <= 1'b0;
            sync_cnt <= '0;
          end
        end
        ST_SYNC: begin
          if (tick) begin
            if (line == LS_SE0) begin
              state <= ST_WAIT_IDLE;
            end else if (line == LS_K && last_k) begin
              state    <= ST_DATA;
              rx_sop   <= 1'b1;
              bit_cnt  <= '0;
              byte_cnt <= '0;
            end else if (sync_cnt == SCW'(SYNC_LIMIT - 1)) begin
              state       <= ST_IDLE;
              rx_sync_err <= 1'b1;
            end else begin
              last_k   <= (line == LS_K);
              sync_cnt <= sync_cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (se0) begin
            state  <= ST_WAIT_IDLE;
            rx_eop <= 1'b1;
          end else if (bit_vld) begin
            sh <= next_byte;
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              if (byte_cnt == BCW'(MAX_BYTES)) begin
                rx_overflow <= 1'b1;
                state       <= ST_WAIT_EOP;
              end else begin
                rx_data  <= next_byte;
                rx_valid <= 1'b1;
                byte_cnt <= byte_cnt + 1'b1;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_WAIT_EOP: begin
          if (line == LS_SE0) state <= ST_WAIT_IDLE;
        end
        default: state <= ST_WAIT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk #(
  parameter int MAX_BYTES = 8
) (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic rx_sop,
  input logic rx_eop,
  input logic rx_overflow,
  input logic rx_sync_err
);

  localparam int CW = $clog2(MAX_BYTES + 2);

  logic          in_pkt;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt <= 1'b0;
      cnt    <= '0;
    end else if (rx_sop) begin
      in_pkt <= 1'b1;
      cnt    <= '0;
    end else if (rx_eop || rx_overflow) begin
      in_pkt <= 1'b0;
    end else if (rx_valid) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_single_event_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid, rx_sop, rx_eop, rx_overflow, rx_sync_err}));

  assert_valid_inside_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> in_pkt);

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_sop_outside_R3: assert property (@(posedge clk) disable iff (rst)
    rx_sop |-> !in_pkt);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (cnt < CW'(MAX_BYTES)));

  assert_overflow_at_limit_R10: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |-> (in_pkt && cnt == CW'(MAX_BYTES)));

  assert_eop_inside_R9: assert property (@(posedge clk) disable iff (rst)
    rx_eop |-> in_pkt);

  assert_sync_err_outside_R4: assert property (@(posedge clk) disable iff (rst)
    rx_sync_err |-> !in_pkt);

endmodule

bind usb_ls_rx usb_ls_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop),
  .rx_eop(rx_eop), .rx_overflow(rx_overflow), .rx_sync_err(rx_sync_err)
);

// File: tb/tb_usb_ls_rx.sv
module tb_usb_ls_rx;

  localparam int MAXB = 8;
  localparam logic [1:0] SJ = 2'b01, SK = 2'b10, S0 = 2'b00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dp = 1'b0, dm = 1'b1;
  logic [7:0] rx_data;
  logic rx_valid, rx_sop, rx_eop, rx_overflow, rx_sync_err;

  always #2.5 clk = ~clk;

  usb_ls_rx #(.MAX_BYTES(MAXB)) dut (
    .clk(clk), .rst(rst), .dp(dp), .dm(dm), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_overflow(rx_overflow), .rx_sync_err(rx_sync_err)
  );

  int n_chk = 0, n_fail = 0;
  int bit_idx = 0;
  logic [7:0] tx [0:31];
  logic [7:0] got [0:63];
  int got_n = 0, c_sop = 0, c_eop = 0, c_ovf = 0, c_serr = 0, c_multi = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid && got_n < 64) begin got[got_n] = rx_data; got_n++; end
      if (rx_sop) c_sop++;
      if (rx_eop) c_eop++;
      if (rx_overflow) c_ovf++;
      if (rx_sync_err) c_serr++;
      if ($countones({rx_valid, rx_sop, rx_eop, rx_overflow, rx_sync_err}) > 1) c_multi++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    got_n = 0; c_sop = 0; c_eop = 0; c_ovf = 0; c_serr = 0; c_multi = 0;
  endtask

  // one bit on the line; bit k lasts floor((k+1)*32/3)-floor(k*32/3) clocks
  task automatic line_bit(input logic [1:0] s);
    int dur;
    {dp, dm} = s;
    dur = ((bit_idx + 1) * 32) / 3 - (bit_idx * 32) / 3;
    bit_idx++;
    repeat (dur) @(negedge clk);
  endtask

  function automatic logic [1:0] flip(input logic [1:0] s);
    return (s == SJ) ? SK : SJ;
  endfunction

  task automatic send_pkt(input int n, input bit sync_ok, input bit omit_tail_stuff);
    logic [1:0] lvl;
    int ones;
    line_bit(SK); line_bit(SJ); line_bit(SK); line_bit(SJ);
    line_bit(SK); line_bit(SJ); line_bit(SK);
    if (!sync_ok) begin
      line_bit(SJ);
      for (int i = 0; i < 14; i++) line_bit(SJ);
      return;
    end
    line_bit(SK);
    lvl = SK; ones = 0;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (!tx[i][b]) begin lvl = flip(lvl); ones = 0; end
        else ones++;
        line_bit(lvl);
        if (ones == 6) begin
          ones = 0;
          if (!(omit_tail_stuff && i == n - 1 && b == 7)) begin
            lvl = flip(lvl);
            line_bit(lvl);
          end
        end
      end
    end
    line_bit(S0); line_bit(S0); line_bit(SJ);
    for (int i = 0; i < 4; i++) line_bit(SJ);
  endtask

  // expected results for a well-formed packet of n bytes
  task automatic judge(input int n, input string req);
    int expn, bad;
    expn = (n > MAXB) ? MAXB : n;
    bad = 0;
    for (int i = 0; i < expn && i < got_n; i++) if (got[i] != tx[i]) bad++;
    chk(c_sop == 1, req, "sop count", c_sop, 1);
    chk(got_n == expn, req, "byte count", got_n, expn);
    chk(bad == 0, req, "mismatched bytes", bad, 0);
    chk(c_eop == ((n > MAXB) ? 0 : 1), req, "eop count", c_eop, (n > MAXB) ? 0 : 1);
    chk(c_ovf == ((n > MAXB) ? 1 : 0), req, "overflow count", c_ovf, (n > MAXB) ? 1 : 0);
    chk(c_multi == 0, "R11", "cycles with several strobes", c_multi, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4711));
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset
    chk({rx_valid, rx_sop, rx_eop, rx_overflow, rx_sync_err} == 5'b0, "R1", "strobes after reset",
        int'({rx_valid, rx_sop, rx_eop, rx_overflow, rx_sync_err}), 0);
    for (int i = 0; i < 6; i++) line_bit(SJ);

    // R2 R3 R6 R8: directed mixed bytes
    clear_mon();
    tx[0] = 8'h2D; tx[1] = 8'h00; tx[2] = 8'h10; tx[3] = 8'hA5;
    send_pkt(4, 1'b1, 1'b0);
    judge(4, "R2/R3/R6/R8");

    // R7: long runs of ones force stuffing
    clear_mon();
    tx[0] = 8'hFF; tx[1] = 8'hFF; tx[2] = 8'h7E; tx[3] = 8'h3F;
    send_pkt(4, 1'b1, 1'b0);
    judge(4, "R7");

    // R12: keep-alive SE0 on idle bus
    clear_mon();
    line_bit(S0); line_bit(S0); line_bit(SJ);
    for (int i = 0; i < 6; i++) line_bit(SJ);
    chk(c_sop + c_eop + c_valid_dummy() + c_ovf + c_serr + got_n == 0, "R12", "strobes on keep-alive",
        c_sop + c_eop + c_ovf + c_serr + got_n, 0);

    // R4: sync without double K
    clear_mon();
    send_pkt(0, 1'b0, 1'b0);
    chk(c_sop == 0, "R4", "sop on bad sync", c_sop, 0);
    chk(c_serr == 1, "R4", "sync error count", c_serr, 1);
    clear_mon();
    tx[0] = 8'h5A;
    send_pkt(1, 1'b1, 1'b0);
    judge(1, "R4 recovery");

    // R10: overflow then recovery
    clear_mon();
    for (int i = 0; i < MAXB + 2; i++) tx[i] = 8'(i * 37 + 1);
    send_pkt(MAXB + 2, 1'b1, 1'b0);
    judge(MAXB + 2, "R10");
    clear_mon();
    tx[0] = 8'hC3; tx[1] = 8'h3C;
    send_pkt(2, 1'b1, 1'b0);
    judge(2, "R10 next packet");

    // R9: SE0 where a stuff bit is due, on a full-length packet
    clear_mon();
    for (int i = 0; i < MAXB - 1; i++) tx[i] = 8'(i + 8'h40);
    tx[MAXB - 1] = 8'hFC;
    send_pkt(MAXB, 1'b1, 1'b1);
    judge(MAXB, "R9");

    // R5: random packets up to the limit
    for (int p = 0; p < 20; p++) begin
      clear_mon();
      n = 1 + int'($urandom % MAXB);
      for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
      if (p % 4 == 0) tx[0] = 8'hFF;
      send_pkt(n, 1'b1, 1'b0);
      judge(n, "R5");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic int c_valid_dummy();
    return 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule